// File: doc/BRIEF.md
# SIMD Vector Pairwise Adder

This block adds neighbouring elements of a packed integer vector in pairs. Two operands of 64 or 128 bits are placed end to end, first operand in the low half and second operand in the high half. Each adjacent pair of elements in that double-width sequence is summed, and the sums are packed into one result of the operand width. As a result, the low half of the output comes from operand A and the high half comes from operand B. This differs from a lane-wise A+B.

A 2-bit size code selects the element width: 8, 16, 32 or 64 bits. A width flag selects a 128-bit or a 64-bit vector. The request is taken when `in_valid` is high. The result, a reserved-encoding flag and an output strobe appear one clock later. They are then held until the next accepted request.

Top module: `vpair_add`

## Requirements
- R1: The element width is 8 << `size_code` (0 = 8 bits, 1 = 16, 2 = 32, 3 = 64). The vector width is 128 bits when `wide_q` = 1 and 64 bits when `wide_q` = 0. There are (vector width / element width) result elements.
- R2: The working sequence is {B[W-1:0], A[W-1:0]}, where W is the vector width. Result elements in the low half of the W-bit result come from pairs within A, and those in the high half come from pairs within B.
- R3: Result element e equals sequence element 2e plus sequence element 2e+1, reduced modulo 2^(element width). No carry crosses an element boundary.
- R4: When `wide_q` = 0, result bits 127..64 are zero.
- R5: `size_code` = 3 with `wide_q` = 0 is reserved. It sets `reserved` and gives an all-zero result.
- R6: Every other encoding, including `size_code` = 3 with `wide_q` = 1, clears `reserved`.
- R7: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high, and low otherwise. `result` and `reserved` belong to that accepted request. Back-to-back requests each produce their own result.
- R8: A clock edge with `in_valid` low leaves `result` and `reserved` unchanged, whatever the operand inputs are.
- R9: A synchronous active-high `rst` clears `out_valid`, `result` and `reserved`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; operands sampled when high |
| op_a | input | 128 | First operand (low half of the sequence) |
| op_b | input | 128 | Second operand (high half of the sequence) |
| size_code | input | 2 | Element width code, width = 8 << code |
| wide_q | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| out_valid | output | 1 | High for one cycle per accepted request |
| result | output | 128 | Packed pairwise sums |
| reserved | output | 1 | Reserved encoding detected |

## Verification
Every result of this block is due exactly one rising edge after the edge that samples `in_valid`. This holds for the sums, the reserved flag and the strobe alike, because only a single register stage sits between inputs and outputs. The bench drives each request on a falling edge and compares all three outputs at the next falling edge, which follows the one capturing edge. Hold behaviour is checked on the falling edge after an idle cycle in which the operands have been scrambled. At that point the outputs must still match the previous request.

// File: rtl/vpair_pkg.sv
package vpair_pkg;

    localparam int unsigned VEC_W     = 128;
    localparam int unsigned HALF_W    = VEC_W / 2;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NUM_SIZES = 4;
    localparam int unsigned SIZE_W    = $clog2(NUM_SIZES);

    typedef enum logic [SIZE_W-1:0] {
        EL_8  = 2'd0,
        EL_16 = 2'd1,
        EL_32 = 2'd2,
        EL_64 = 2'd3
    } elem_size_e;

    typedef struct packed {
        logic [VEC_W-1:0] a;
        logic [VEC_W-1:0] b;
        elem_size_e       size;
        logic             wide;
    } pair_req_t;

    typedef struct packed {
        logic [VEC_W-1:0] data;
        logic             rsv;
    } pair_rsp_t;

    // Element width for a size code
    function automatic int unsigned elem_bits(input int unsigned code);
        return BYTE_W << code;
    endfunction

    // Widest elements in a narrow vector leave only one element: not a pair
    function automatic logic is_reserved(input elem_size_e s, input logic wide);
        return (s == EL_64) && !wide;
    endfunction

endpackage

// File: rtl/vpair_fold.sv
// Sums adjacent EW-bit elements of an IW-bit input; output is IW/2 bits.
module vpair_fold #(
    parameter int unsigned EW = 8,
    parameter int unsigned IW = 128
) (
    input  logic [IW-1:0]   din,
    output logic [IW/2-1:0] dout
);
    localparam int unsigned NP = IW / (2 * EW);

    for (genvar p = 0; p < NP; p++) begin : g_pair
        // Sum truncates to EW: carries stay within the element
        assign dout[p*EW +: EW] = din[(2*p)*EW +: EW] + din[(2*p+1)*EW +: EW];
    end
endmodule

// File: rtl/vpair_lanes.sv
// Builds one candidate per element width and vector width, then selects.
module vpair_lanes
    import vpair_pkg::*;
(
    input  pair_req_t req,
    output pair_rsp_t rsp
);
    logic [VEC_W-1:0] cand_wide   [NUM_SIZES];
    logic [VEC_W-1:0] cand_narrow [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int unsigned EW = elem_bits(s);

        logic [HALF_W-1:0] sum_a_w;
        logic [HALF_W-1:0] sum_b_w;

        vpair_fold #(.EW(EW), .IW(VEC_W)) u_fold_a_w (
            .din  (req.a),
            .dout (sum_a_w)
        );
        vpair_fold #(.EW(EW), .IW(VEC_W)) u_fold_b_w (
            .din  (req.b),
            .dout (sum_b_w)
        );
        // First operand fills the low half, second the high half
        assign cand_wide[s] = {sum_b_w, sum_a_w};

        if (2 * EW <= HALF_W) begin : g_narrow
            logic [HALF_W/2-1:0] sum_a_n;
            logic [HALF_W/2-1:0] sum_b_n;

            vpair_fold #(.EW(EW), .IW(HALF_W)) u_fold_a_n (
                .din  (req.a[HALF_W-1:0]),
                .dout (sum_a_n)
            );
            vpair_fold #(.EW(EW), .IW(HALF_W)) u_fold_b_n (
                .din  (req.b[HALF_W-1:0]),
                .dout (sum_b_n)
            );
            assign cand_narrow[s] = {{HALF_W{1'b0}}, sum_b_n, sum_a_n};
        end else begin : g_no_narrow
            assign cand_narrow[s] = '0;
        end
    end

    always_comb begin
        rsp.rsv = is_reserved(req.size, req.wide);
        if (rsp.rsv) begin
            rsp.data = '0;
        end else if (req.wide) begin
            rsp.data = cand_wide[req.size];
        end else begin
            rsp.data = cand_narrow[req.size];
        end
    end
endmodule

// File: rtl/vpair_add.sv
module vpair_add
    import vpair_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [VEC_W-1:0]     op_a,
    input  logic [VEC_W-1:0]     op_b,
    input  logic [SIZE_W-1:0]    size_code,
    input  logic                 wide_q,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     result,
    output logic                 reserved
);
    pair_req_t req_d;
    pair_rsp_t rsp_d;
    pair_rsp_t rsp_q;
    logic      vld_q;

    always_comb begin
        req_d.a    = op_a;
        req_d.b    = op_b;
        req_d.size = elem_size_e'(size_code);
        req_d.wide = wide_q;
    end

    vpair_lanes u_lanes (
        .req (req_d),
        .rsp (rsp_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            rsp_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                rsp_q <= rsp_d;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = rsp_q.data;
    assign reserved  = rsp_q.rsv;
endmodule

// File: rtl/vpair_add_chk.sv
module vpair_add_chk
    import vpair_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [VEC_W-1:0]     op_a,
    input logic [VEC_W-1:0]     op_b,
    input logic [SIZE_W-1:0]    size_code,
    input logic                 wide_q,
    input logic                 out_valid,
    input logic [VEC_W-1:0]     result,
    input logic                 reserved
);
    a_r7_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_no_spurious_strobe: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(reserved)));

    a_r4_narrow_high_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_q) |=> (result[VEC_W-1:HALF_W] == '0));

    a_r5_reserved_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_q && size_code == 2'd3) |=> (reserved && result == '0));

    a_r6_legal_flag_low: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(!wide_q && size_code == 2'd3)) |=> !reserved);

    a_r3_low_byte_sum: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide_q && size_code == 2'd0) |=>
        (result[7:0] == 8'($past(op_a[7:0]) + $past(op_a[15:8]))));

    a_r2_top_byte_from_b: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide_q && size_code == 2'd0) |=>
        (result[127:120] == 8'($past(op_b[119:112]) + $past(op_b[127:120]))));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !reserved && result == '0));
endmodule

bind vpair_add vpair_add_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .size_code (size_code),
    .wide_q    (wide_q),
    .out_valid (out_valid),
    .result    (result),
    .reserved  (reserved)
);

// File: tb/vpair_add_bench.sv
`timescale 1ns/1ps
module vpair_add_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] op_a;
    logic [127:0] op_b;
    logic [1:0]   size_code;
    logic         wide_q;
    logic         out_valid;
    logic [127:0] result;
    logic         reserved;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    always #2 clk = ~clk;

    vpair_add u_vpair_add (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .size_code (size_code),
        .wide_q    (wide_q),
        .out_valid (out_valid),
        .result    (result),
        .reserved  (reserved)
    );

    // Expected result from the requirements
    function automatic logic [127:0] expect_sum(input logic [127:0] a, input logic [127:0] b,
                                                input int sz, input bit q);
        logic [255:0] seq;
        logic [127:0] r;
        logic [64:0]  x;
        logic [64:0]  y;
        logic [64:0]  s;
        int w;
        int ew;
        r = '0;
        if (sz == 3 && !q) return r;
        ew  = 8 << sz;
        w   = q ? 128 : 64;
        seq = '0;
        for (int i = 0; i < w; i++) begin
            seq[i]     = a[i];
            seq[w + i] = b[i];
        end
        for (int e = 0; e < w / ew; e++) begin
            x = '0;
            y = '0;
            for (int k = 0; k < ew; k++) begin
                x[k] = seq[(2*e)*ew + k];
                y[k] = seq[(2*e+1)*ew + k];
            end
            s = x + y;
            for (int k = 0; k < ew; k++) r[e*ew + k] = s[k];
        end
        return r;
    endfunction

    function automatic logic [127:0] pattern(input int idx);
        case (idx)
            0: return '1;
            1: return {16{8'h80}};
            2: return {8{16'h5555}};
            3: return {8{16'hAAAA}};
            4: return '0;
            5: return {2{64'h8000_0000_8000_0000}};
            default: return {$urandom, $urandom, $urandom, $urandom};
        endcase
    endfunction

    task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        logic [127:0] exp_r;
        logic [127:0] last_r;
        bit           last_rsv;
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; size_code = '0; wide_q = 1'b0;
        repeat (3) @(negedge clk);
        check({127'd0, out_valid}, 128'd0, "R9 out_valid");
        check(result, 128'd0, "R9 result");
        check({127'd0, reserved}, 128'd0, "R9 reserved");
        rst = 1'b0;
        last_r = '0; last_rsv = 1'b0;

        for (int q = 0; q < 2; q++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int v = 0; v < 24; v++) begin
                    bit rsv_exp;
                    in_valid  = 1'b1;
                    op_a      = pattern(v);
                    op_b      = pattern((v + 3) % 24);
                    size_code = 2'(sz);
                    wide_q    = q[0];
                    exp_r     = expect_sum(op_a, op_b, sz, q[0]);
                    rsv_exp   = (sz == 3 && q == 0);
                    @(negedge clk);
                    check({127'd0, out_valid}, 128'd1, "R7 out_valid");
                    if (rsv_exp) begin
                        check({127'd0, reserved}, 128'd1, "R5 flag");
                        check(result, 128'd0, "R5 zero result");
                    end else begin
                        check({127'd0, reserved}, 128'd0, "R6 flag");
                        check({64'd0, result[63:0]}, {64'd0, exp_r[63:0]}, "R2 low half from A");
                        check(result, exp_r, "R1/R3 pair sums");
                        if (q == 0) check({64'd0, result[127:64]}, 128'd0, "R4 high zero");
                    end
                    last_r = exp_r; last_rsv = rsv_exp;
                    if (v % 6 == 5) begin
                        in_valid  = 1'b0;
                        op_a      = ~op_a;
                        op_b      = op_b ^ {4{32'h1234_5678}};
                        size_code = ~size_code;
                        wide_q    = ~wide_q;
                        @(negedge clk);
                        check({127'd0, out_valid}, 128'd0, "R7 idle strobe");
                        check(result, last_r, "R8 result held");
                        check({127'd0, reserved}, {127'd0, last_rsv}, "R8 flag held");
                    end
                end
            end
        end

        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check({127'd0, out_valid}, 128'd0, "R9 out_valid again");
        check(result, 128'd0, "R9 result again");
        rst = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule